// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Hi/Lo Result Registers

This block performs multiplication and division of two operands, one bit per cycle, and keeps each result in two dedicated result registers, hi and lo. A requester pulses a start strobe together with an operation code and two operands. The unit then raises busy, runs for WIDTH iterations and writes both result registers in the same cycle that busy falls. The outputs of hi and lo are always readable. Move-from-hi and move-from-lo instructions read them directly.

A multiply leaves the full double-width product across the pair: the upper half goes to hi and the lower half to lo. A divide leaves the quotient in lo and the remainder in hi. Signed operations run on magnitudes, and the signs are corrected in the final cycle.

Top module: `mdu_hilo`

## Requirements
- R1: While reset is asserted, and right after it, hi_o and lo_o read zero and busy_o reads 0.
- R2: A start_i sampled high while busy_o is low makes busy_o high from the next cycle for exactly WIDTH cycles. hi_o and lo_o take the result on the clock edge where busy_o returns low.
- R3: A start_i pulse while busy_o is high is ignored: the operation in flight completes unchanged, with its own result and timing.
- R4: op_i = 2'b00 is an unsigned multiply. hi_o:lo_o holds the 2*WIDTH-bit unsigned product, with the upper half in hi_o.
- R5: op_i = 2'b01 is a signed (two's complement) multiply. hi_o:lo_o holds the 2*WIDTH-bit signed product.
- R6: op_i = 2'b10 is an unsigned divide of a_i by b_i. The quotient goes to lo_o and the remainder to hi_o.
- R7: op_i = 2'b11 is a signed divide. The quotient truncates toward zero and the remainder takes the sign of the dividend. Both are kept modulo 2^WIDTH, so the most negative value divided by -1 gives the most negative value with remainder 0.
- R8: Division by zero, signed or unsigned, completes normally and sets lo_o to all ones and hi_o to a_i.
- R9: hi_o and lo_o change only on the edge that completes an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 2 | Bit 1: divide; bit 0: signed |
| a_i | input | WIDTH | Multiplicand or dividend |
| b_i | input | WIDTH | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is in progress |
| hi_o | output | WIDTH | Hi register: product upper half or remainder |
| lo_o | output | WIDTH | Lo register: product lower half or quotient |

## Verification
The bench builds the unit with WIDTH = 8. At that width the extreme operands can be checked directly against integer arithmetic: the most negative value, -1, zero divisors and the all-ones operand. Each operation also finishes in a few cycles, so hundreds of operations of every kind fit in a short run. Start pulses placed in the middle of an operation show that the in-flight result and its completion edge are not disturbed.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [1:0] {
        OP_MULU = 2'b00,
        OP_MULS = 2'b01,
        OP_DIVU = 2'b10,
        OP_DIVS = 2'b11
    } mdu_op_e;
endpackage

// File: rtl/mdu_prep.sv
module mdu_prep #(
    parameter int WIDTH = 32
) (
    input  logic             sgn_i,
    input  logic [WIDTH-1:0] val_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    always_comb begin
        neg_o = sgn_i & val_i[WIDTH-1];
        mag_o = neg_o ? (~val_i + 1'b1) : val_i;
    end
endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
    parameter int WIDTH = 32
) (
    input  logic             is_div_i,
    input  logic [WIDTH:0]   upper_i,
    input  logic [WIDTH-1:0] lower_i,
    input  logic [WIDTH-1:0] oper_i,
    output logic [WIDTH:0]   upper_o,
    output logic [WIDTH-1:0] lower_o
);
    logic [WIDTH:0] sum;
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] trial;

    always_comb begin
        sum     = {1'b0, upper_i[WIDTH-1:0]} + (lower_i[0] ? {1'b0, oper_i} : '0);
        shifted = {upper_i[WIDTH-1:0], lower_i[WIDTH-1]};
        trial   = shifted - {1'b0, oper_i};
        if (is_div_i) begin
            if (!trial[WIDTH]) begin
                upper_o = trial;
                lower_o = {lower_i[WIDTH-2:0], 1'b1};
            end else begin
                upper_o = shifted;
                lower_o = {lower_i[WIDTH-2:0], 1'b0};
            end
        end else begin
            upper_o = {1'b0, sum[WIDTH:1]};
            lower_o = {sum[0], lower_i[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/mdu_fixup.sv
module mdu_fixup #(
    parameter int WIDTH = 32
) (
    input  logic             is_div_i,
    input  logic             neg_a_i,
    input  logic             neg_b_i,
    input  logic             div_zero_i,
    input  logic [WIDTH:0]   upper_i,
    input  logic [WIDTH-1:0] lower_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    prod;
    logic [WIDTH-1:0] quo;
    logic [WIDTH-1:0] rem;

    always_comb begin
        prod = {upper_i[WIDTH-1:0], lower_i};
        if (neg_a_i ^ neg_b_i) prod = ~prod + 1'b1;
        quo = lower_i;
        rem = upper_i[WIDTH-1:0];
        if (neg_a_i ^ neg_b_i) quo = ~quo + 1'b1;
        if (neg_a_i) rem = ~rem + 1'b1;
        if (div_zero_i) quo = '1;
        if (is_div_i) begin
            hi_o = rem;
            lo_o = quo;
        end else begin
            hi_o = prod[PW-1:WIDTH];
            lo_o = prod[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
    import mdu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic             is_div;
        logic             neg_a;
        logic             neg_b;
        logic             div_zero;
        logic [WIDTH:0]   upper;
        logic [WIDTH-1:0] lower;
        logic [WIDTH-1:0] oper;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
    } mdu_state_t;

    mdu_state_t st_d, st_q;
    mdu_op_e    op;

    logic [WIDTH-1:0] mag_a, mag_b;
    logic             sgn_a, sgn_b;
    logic [WIDTH:0]   step_upper;
    logic [WIDTH-1:0] step_lower;
    logic [WIDTH-1:0] fix_hi, fix_lo;

    assign op = mdu_op_e'(op_i);

    mdu_prep #(.WIDTH(WIDTH)) u_prep_a (
        .sgn_i(op_i[0]), .val_i(a_i), .mag_o(mag_a), .neg_o(sgn_a)
    );
    mdu_prep #(.WIDTH(WIDTH)) u_prep_b (
        .sgn_i(op_i[0]), .val_i(b_i), .mag_o(mag_b), .neg_o(sgn_b)
    );

    mdu_step #(.WIDTH(WIDTH)) u_step (
        .is_div_i(st_q.is_div), .upper_i(st_q.upper), .lower_i(st_q.lower),
        .oper_i(st_q.oper), .upper_o(step_upper), .lower_o(step_lower)
    );

    mdu_fixup #(.WIDTH(WIDTH)) u_fixup (
        .is_div_i(st_q.is_div), .neg_a_i(st_q.neg_a), .neg_b_i(st_q.neg_b),
        .div_zero_i(st_q.div_zero), .upper_i(step_upper), .lower_i(step_lower),
        .hi_o(fix_hi), .lo_o(fix_lo)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.upper = step_upper;
            st_d.lower = step_lower;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.hi   = fix_hi;
                st_d.lo   = fix_lo;
            end
        end else if (start_i) begin
            st_d.busy     = 1'b1;
            st_d.cnt      = '0;
            st_d.is_div   = (op == OP_DIVU) || (op == OP_DIVS);
            st_d.neg_a    = sgn_a;
            st_d.neg_b    = sgn_b;
            st_d.div_zero = (b_i == '0);
            st_d.upper    = '0;
            st_d.lower    = mag_a;
            st_d.oper     = mag_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign hi_o   = st_q.hi;
    assign lo_o   = st_q.lo;

    // checker state: independent busy-length counter and busy history
    logic [CW-1:0] chk_len_q;
    logic          chk_busy_prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_len_q       <= '0;
            chk_busy_prev_q <= 1'b0;
        end else begin
            chk_len_q       <= busy_o ? chk_len_q + 1'b1 : '0;
            chk_busy_prev_q <= busy_o;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (hi_o == '0 && lo_o == '0 && !busy_o));

    assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && chk_len_q != LAST) |=> busy_o);

    assert_busy_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && chk_len_q == LAST) |=> !busy_o);

    assert_start_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_busy_prev_q && !busy_o) |-> $stable({hi_o, lo_o}));
endmodule

// File: tb/tb_mdu_hilo.sv
module tb_mdu_hilo;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         busy_o;
    logic [W-1:0] hi_o, lo_o;

    int tests = 0;
    int fails = 0;
    string tag = "R1";
    logic checking = 1'b0;

    mdu_hilo #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    always #10 clk = ~clk;

    // reference model
    logic         m_busy = 1'b0;
    int           m_cnt = 0;
    logic [W-1:0] m_hi = '0, m_lo = '0;
    logic [W-1:0] p_hi, p_lo;

    function automatic logic [2*W-1:0] ref_result(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
        longint sa, sb, r, q;
        logic [2*W-1:0] res;
        if (op[0]) begin
            sa = $signed(a);
            sb = $signed(b);
        end else begin
            sa = longint'(a);
            sb = longint'(b);
        end
        if (!op[1]) begin
            r = sa * sb;
            res = r[2*W-1:0];
        end else if (b == '0) begin
            res = {a, {W{1'b1}}};
        end else begin
            q = sa / sb;
            r = sa % sb;
            res = {r[W-1:0], q[W-1:0]};
        end
        return res;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_cnt  <= 0;
            m_hi   <= '0;
            m_lo   <= '0;
        end else if (m_busy) begin
            m_cnt <= m_cnt + 1;
            if (m_cnt + 1 == W) begin
                m_busy <= 1'b0;
                m_hi   <= p_hi;
                m_lo   <= p_lo;
            end
        end else if (start_i) begin
            m_busy <= 1'b1;
            m_cnt  <= 0;
            {p_hi, p_lo} <= ref_result(op_i, a_i, b_i);
        end
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            check("R2", {{(W-1){1'b0}}, busy_o}, {{(W-1){1'b0}}, m_busy}, "busy");
            check(tag, hi_o, m_hi, "hi (R9 hold)");
            check(tag, lo_o, m_lo, "lo (R9 hold)");
        end
    end

    task automatic run_op(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b, string t, bit poke);
        @(negedge clk);
        tag = t;
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < W + 1; i++) begin
            if (poke && i == 2) begin
                start_i = 1'b1; op_i = ~op; a_i = ~a; b_i = b + 8'd3; // R3 stray start
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    function automatic string op_tag(logic [1:0] op);
        case (op)
            2'b00: return "R4";
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] lf;
        logic [W-1:0] corner [6];
        corner[0] = 8'h00; corner[1] = 8'h01; corner[2] = 8'hFF;
        corner[3] = 8'h80; corner[4] = 8'h7F; corner[5] = 8'h05;
        repeat (3) @(negedge clk);
        check("R1", hi_o, '0, "hi in reset");
        check("R1", lo_o, '0, "lo in reset");
        check("R1", {{(W-1){1'b0}}, busy_o}, '0, "busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", hi_o, '0, "hi after reset");
        check("R1", lo_o, '0, "lo after reset");
        checking = 1'b1;
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    run_op(2'(op), corner[i], corner[j],
                           (op[1] && corner[j] == 0) ? "R8" : op_tag(2'(op)), 1'b0);
                end
            end
        end
        lf = 8'h5A;
        for (int k = 0; k < 200; k++) begin
            logic [W-1:0] x, y;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            x = lf;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            y = lf;
            run_op(2'(k % 4), x, y, (k % 7 == 0) ? "R3" : op_tag(2'(k % 4)), (k % 7 == 0));
        end
        run_op(2'b11, 8'h80, 8'hFF, "R7", 1'b0);
        run_op(2'b11, 8'hF9, 8'h02, "R7", 1'b1);
        run_op(2'b10, 8'h37, 8'h00, "R8", 1'b0);
        run_op(2'b11, 8'h80, 8'h00, "R8", 1'b0);
        checking = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule